// File: doc/BRIEF.md
# Adaptive-Threshold Foreground Segmenter

This block separates moving objects from a static scene in a stream of grayscale pixels. Each beat carries a pixel of the live frame together with the co-located pixel of a stored reference (background) image. The block emits one mask bit per pixel: 1 marks foreground, 0 marks background. Pixels are 8 bits and a frame is `FRAME_W` by `FRAME_H` pixels, 128 by 128 unless overridden. The pixel count must be a power of two.

A fixed threshold floods the mask with false foreground whenever scene lighting shifts. To avoid this, the decision threshold is the sum of two terms. The first is a programmable base gray level. The second is a dynamic offset that follows global illumination change. For every frame the block adds up the absolute pixel differences and multiplies the total by a programmable suppression coefficient. Dividing by the pixel count, done as a right shift, gives the offset used for the whole of the next frame. A coefficient of 2 is the nominal setting.

A steady scene gives a small mean difference, so the offset falls toward zero. A global brightness jump raises every difference, so the offset rises with it. The stream uses valid/ready handshaking with frame-start and frame-end markers. All stages stall together when the consumer is not ready.

Top module: `adaptive_bgsub`

## Requirements
- R1: `outMask` is 1 exactly when |curPix − refPix| is strictly greater than the threshold in force for that pixel. The difference is symmetric in its two operands, and a difference equal to the threshold gives 0.
- R2: The threshold equals `baseThr` plus the dynamic offset dT, and saturates at 255.
- R3: When a frame ends, dT becomes (inhibCoef × S) >> log2(FRAME_W·FRAME_H). S is the sum of |curPix − refPix| over the accepted pixels from the pixel with `inSof` high through the pixel with `inEof` high, both included. An `inSof` pixel discards any partial sum and restarts S.
- R4: A new dT applies from the first pixel accepted after the `inEof` pixel. The `inEof` pixel itself, and every pixel before it, uses the previous dT. dT changes at no other time.
- R5: After reset, dT is 0 until the first `inEof` pixel is accepted.
- R6: A pixel accepted in cycle c, with `outReady` high in cycle c+1, appears on `outValid`, `outMask`, `outSof` and `outEof` in cycle c+2. This is two register stages, and `outSof`/`outEof` travel with their pixel.
- R7: `inReady` equals `outReady`. While `outReady` is low, no pixel is accepted and all four outputs hold their values.
- R8: During and right after reset, `outValid`, `outMask`, `outSof` and `outEof` are 0.
- R9: With `inhibCoef` = 0 at the end of a frame, dT for the next frame is 0 whatever the differences were.
- R10: If more than FRAME_W·FRAME_H pixels arrive before `inEof`, S saturates at 2^(8+log2(FRAME_W·FRAME_H)) − 1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Block accepts a beat this cycle |
| inSof | input | 1 | Beat is the first pixel of a frame |
| inEof | input | 1 | Beat is the last pixel of a frame |
| curPix | input | PIX_W | Live frame pixel |
| refPix | input | PIX_W | Background pixel at the same location |
| baseThr | input | PIX_W | Programmable base threshold |
| inhibCoef | input | COEF_W | Programmable suppression coefficient |
| outReady | input | 1 | Consumer accepts output |
| outValid | output | 1 | Output beat valid |
| outMask | output | 1 | Foreground (1) or background (1'b0) |
| outSof | output | 1 | Output beat starts a frame |
| outEof | output | 1 | Output beat ends a frame |

## Verification
A corrupted frame sum or dT register cannot be seen in the frame where it goes wrong. It only shows up in the masks of the following frame, and only on pixels whose difference lies between the correct threshold and the wrong one. For this reason the sweep runs many back-to-back frames with varied coefficients, base levels and difference spreads, so that nearly every threshold value gets crossed. A pipeline slip shows up within two cycles, as a latency mismatch or a frame marker on the wrong pixel. Saturation paths are driven on purpose: a base threshold near 255 with a large offset, and an overlong frame of maximum differences.

// File: rtl/adaptive_bgsub_pkg.sv
package adaptive_bgsub_pkg;

  // Strobes from the control unit to the datapath, all for the current cycle.
  typedef struct packed {
    logic advance;     // pipeline registers move
    logic take;        // an input beat is accepted
    logic frameStart;  // accepted beat opens a frame
    logic frameEnd;    // accepted beat closes a frame
  } pipeCtrl_t;

endpackage

// File: rtl/adaptive_bgsub_ctrl.sv
module adaptive_bgsub_ctrl
  import adaptive_bgsub_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inSof,
  input  logic       inEof,
  input  logic       outReady,
  output logic       inReady,
  output pipeCtrl_t  ctl,
  output logic       outValid,
  output logic       outSof,
  output logic       outEof
);

  logic s1Valid, s1Sof, s1Eof;

  // The whole pipeline stalls as one unit, so input readiness is the consumer's.
  assign inReady        = outReady;
  assign ctl.advance    = outReady;
  assign ctl.take       = inValid && outReady;
  assign ctl.frameStart = ctl.take && inSof;
  assign ctl.frameEnd   = ctl.take && inEof;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s1Sof    <= 1'b0;
      s1Eof    <= 1'b0;
      outValid <= 1'b0;
      outSof   <= 1'b0;
      outEof   <= 1'b0;
    end else if (ctl.advance) begin
      s1Valid  <= inValid;
      s1Sof    <= inValid && inSof;
      s1Eof    <= inValid && inEof;
      outValid <= s1Valid;
      outSof   <= s1Sof;
      outEof   <= s1Eof;
    end
  end

  // R7: a stalled output beat stays put with its markers
  p_hold_when_stalled_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outSof) && $stable(outEof)));

  // R6: an accepted beat reaches the output two cycles later
  p_two_cycle_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) ##1 outReady |=> outValid);

  // R6: markers never appear without a valid beat
  p_markers_need_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outSof || outEof) |-> outValid);

endmodule

// File: rtl/adaptive_bgsub_illum.sv
module adaptive_bgsub_illum
  import adaptive_bgsub_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 4,
  parameter int SHIFT  = 14
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pipeCtrl_t               ctl,
  input  logic [PIX_W-1:0]        absDiff,
  input  logic [COEF_W-1:0]       inhibCoef,
  output logic [PIX_W+COEF_W-1:0] dynTerm
);

  localparam int ACC_W  = PIX_W + SHIFT;
  localparam int PROD_W = ACC_W + COEF_W;

  logic [ACC_W-1:0]  accum;
  logic [ACC_W:0]    sumWide;
  logic [ACC_W-1:0]  frameSum;
  logic [PROD_W-1:0] product;

  // A frame-start beat discards any partial sum.
  always_comb begin
    if (ctl.frameStart) sumWide = (ACC_W+1)'(absDiff);
    else                sumWide = {1'b0, accum} + (ACC_W+1)'(absDiff);
    frameSum = sumWide[ACC_W] ? {ACC_W{1'b1}} : sumWide[ACC_W-1:0];
    product  = PROD_W'(frameSum) * PROD_W'(inhibCoef);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accum   <= '0;
      dynTerm <= '0;
    end else if (ctl.take) begin
      if (ctl.frameEnd) begin
        accum   <= '0;
        dynTerm <= product[PROD_W-1:SHIFT];
      end else begin
        accum   <= frameSum;
      end
    end
  end

  // Checker state: has any frame ended since reset?
  logic seenEnd;
  always_ff @(posedge clk) begin
    if (!rstN)             seenEnd <= 1'b0;
    else if (ctl.frameEnd) seenEnd <= 1'b1;
  end

  // R5: no offset before the first full frame
  p_zero_until_first_frame_r5: assert property (@(posedge clk) disable iff (!rstN)
    !seenEnd |-> (dynTerm == '0));

  // R4: the offset moves only on an accepted frame end
  p_offset_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.frameEnd |=> $stable(dynTerm));

  // R10: inside a frame the running sum never wraps downward
  p_sum_no_wrap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.take && !ctl.frameStart && !ctl.frameEnd) |=> (accum >= $past(accum)));

endmodule

// File: rtl/adaptive_bgsub_dp.sv
module adaptive_bgsub_dp
  import adaptive_bgsub_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 4,
  parameter int SHIFT  = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  pipeCtrl_t         ctl,
  input  logic [PIX_W-1:0]  curPix,
  input  logic [PIX_W-1:0]  refPix,
  input  logic [PIX_W-1:0]  baseThr,
  input  logic [COEF_W-1:0] inhibCoef,
  output logic              outMask
);

  localparam int DT_W = PIX_W + COEF_W;

  logic [PIX_W-1:0] absDiff;
  logic [DT_W-1:0]  dynTerm;
  logic [DT_W:0]    thrWide;
  logic [PIX_W-1:0] thrNow;
  logic [PIX_W-1:0] s1Diff;
  logic [PIX_W-1:0] s1Thr;

  always_comb begin
    absDiff = (curPix >= refPix) ? (curPix - refPix) : (refPix - curPix);
    thrWide = (DT_W+1)'(baseThr) + (DT_W+1)'(dynTerm);
    thrNow  = (|thrWide[DT_W:PIX_W]) ? {PIX_W{1'b1}} : thrWide[PIX_W-1:0];
  end

  adaptive_bgsub_illum #(
    .PIX_W (PIX_W),
    .COEF_W(COEF_W),
    .SHIFT (SHIFT)
  ) u_illum (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .absDiff  (absDiff),
    .inhibCoef(inhibCoef),
    .dynTerm  (dynTerm)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Diff  <= '0;
      s1Thr   <= '0;
      outMask <= 1'b0;
    end else if (ctl.advance) begin
      s1Diff  <= absDiff;
      s1Thr   <= thrNow;
      outMask <= (s1Diff > s1Thr);
    end
  end

  // R2: the staged threshold is never below the base level (no wrap)
  p_thr_floor_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take |=> (s1Thr >= $past(baseThr)));

  // R1: identical pixels are never foreground
  p_equal_is_background_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.take && (curPix == refPix)) ##1 ctl.advance |=> !outMask);

endmodule

// File: rtl/adaptive_bgsub.sv
module adaptive_bgsub
  import adaptive_bgsub_pkg::*;
#(
  parameter int FRAME_W = 128,
  parameter int FRAME_H = 128,
  parameter int PIX_W   = 8,
  parameter int COEF_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic              inSof,
  input  logic              inEof,
  input  logic [PIX_W-1:0]  curPix,
  input  logic [PIX_W-1:0]  refPix,
  input  logic [PIX_W-1:0]  baseThr,
  input  logic [COEF_W-1:0] inhibCoef,
  input  logic              outReady,
  output logic              outValid,
  output logic              outMask,
  output logic              outSof,
  output logic              outEof
);

  localparam int PIXELS = FRAME_W * FRAME_H;
  localparam int SHIFT  = $clog2(PIXELS);

  pipeCtrl_t ctl;

  initial begin
    p_pow2_frame_r3: assert (PIXELS == (1 << SHIFT));
  end

  adaptive_bgsub_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inSof   (inSof),
    .inEof   (inEof),
    .outReady(outReady),
    .inReady (inReady),
    .ctl     (ctl),
    .outValid(outValid),
    .outSof  (outSof),
    .outEof  (outEof)
  );

  adaptive_bgsub_dp #(
    .PIX_W (PIX_W),
    .COEF_W(COEF_W),
    .SHIFT (SHIFT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .curPix   (curPix),
    .refPix   (refPix),
    .baseThr  (baseThr),
    .inhibCoef(inhibCoef),
    .outMask  (outMask)
  );

endmodule

// File: tb/sim_adaptive_bgsub.sv
module sim_adaptive_bgsub;

  localparam int W = 4;
  localparam int H = 4;
  localparam int SH = 4;          // log2(W*H)
  localparam int ACC_MAX = 4095;  // 2^(8+SH) - 1

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic [7:0] curPix = '0, refPix = '0, baseThr = '0;
  logic [3:0] inhibCoef = '0;
  logic outReady = 1'b1;
  logic inReady, outValid, outMask, outSof, outEof;

  always #10 clk = ~clk;

  adaptive_bgsub #(.FRAME_W(W), .FRAME_H(H), .PIX_W(8), .COEF_W(4)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inSof(inSof), .inEof(inEof), .curPix(curPix), .refPix(refPix),
    .baseThr(baseThr), .inhibCoef(inhibCoef), .outReady(outReady),
    .outValid(outValid), .outMask(outMask), .outSof(outSof), .outEof(outEof));

  int checks = 0;
  int fails = 0;
  int negCount = 0;
  bit stallSection = 1'b0;
  string tag = "R1";

  // bench model state
  int mSum = 0;
  int mDt = 0;
  bit qMask[$];
  bit qSof[$];
  bit qEof[$];
  int qStamp[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference computation straight from R1-style rules (R1 R2 R3 R4 R10)
  task automatic modelPush(input int c, input int r, input bit s, input bit e);
    int d, thr;
    d = (c > r) ? c - r : r - c;
    thr = int'(baseThr) + mDt;
    if (thr > 255) thr = 255;
    qMask.push_back(d > thr);
    qSof.push_back(s);
    qEof.push_back(e);
    qStamp.push_back(negCount);
    if (s) mSum = d; else mSum = mSum + d;
    if (mSum > ACC_MAX) mSum = ACC_MAX;
    if (e) begin
      mDt = (int'(inhibCoef) * mSum) >> SH;
      mSum = 0;
    end
  endtask

  task automatic sendPix(input int c, input int r, input bit s, input bit e);
    @(negedge clk);
    inValid = 1'b1; curPix = 8'(c); refPix = 8'(r); inSof = s; inEof = e;
    do @(posedge clk); while (!outReady);
    modelPush(c, r, s, e);
  endtask

  task automatic setCfg(input int b, input int a);
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
    baseThr = 8'(b); inhibCoef = 4'(a);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // output monitor
  always @(negedge clk) begin
    negCount++;
    if (rstN && outValid && outReady) begin
      if (qMask.size() == 0) begin
        chk(1'b0, "R6", "unexpected output beat", 1, 0);
      end else begin
        bit em, es, ee;
        int st;
        em = qMask.pop_front(); es = qSof.pop_front();
        ee = qEof.pop_front(); st = qStamp.pop_front();
        chk(outMask == em, {tag, " R1"}, "mask", int'(outMask), int'(em));
        chk(outSof == es, "R6", "sof marker", int'(outSof), int'(es));
        chk(outEof == ee, "R6", "eof marker", int'(outEof), int'(ee));
        if (!stallSection)
          chk(negCount - st == 2, "R6", "latency", negCount - st, 2);
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // reset
    repeat (4) @(negedge clk);
    chk(outValid == 1'b0, "R8", "outValid in reset", int'(outValid), 0);
    chk(outMask == 1'b0 && outSof == 1'b0 && outEof == 1'b0, "R8", "outputs in reset", int'(outMask), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R8", "outValid after reset", int'(outValid), 0);
    chk(inReady == 1'b1, "R7", "inReady follows outReady", int'(inReady), 1);

    // Frame A: dT is 0 after reset; boundary diffs around base 10 (R5, R1)
    tag = "R5";
    setCfg(10, 2);
    for (int i = 0; i < 16; i++) begin
      int d;
      d = (i < 8) ? 6 + i : 30 * (i - 7);
      if (d > 255) d = 255;
      if (i[0]) sendPix(100 + (d / 2), 100 + (d / 2) - d, i == 0, i == 15);
      else      sendPix(d, 0, i == 0, i == 15);
    end

    // Frame B: uniform diff 16, coef 1 -> next dT 16; eof pixel still old dT (R4)
    tag = "R4";
    setCfg(0, 1);
    for (int i = 0; i < 16; i++) sendPix(50, 66, i == 0, i == 15);

    // Frame C: diffs 16/17 against threshold 16 (R3)
    tag = "R3";
    setCfg(0, 0);
    for (int i = 0; i < 16; i++) sendPix(80 + 16 + (i % 2), 80, i == 0, i == 15);

    // Frame D: coef was 0 at end of C -> dT 0; diff 1 vs base 0 (R9)
    tag = "R9";
    setCfg(0, 15);
    for (int i = 0; i < 16; i++) sendPix(i % 3, 0, i == 0, i == 15);
    // Frame E: big diffs, coef 15 from D; base 250 -> threshold saturates (R2)
    tag = "R2";
    setCfg(250, 15);
    for (int i = 0; i < 16; i++) sendPix(255, 255 - (i * 17), i == 0, i == 15);
    setCfg(250, 15);
    for (int i = 0; i < 16; i++) sendPix(255, 0, i == 0, i == 15);

    // sof restart drops a partial frame (R3)
    tag = "R3";
    setCfg(0, 1);
    for (int i = 0; i < 5; i++) sendPix(255, 0, i == 0, 1'b0);
    for (int i = 0; i < 16; i++) sendPix(4, 0, i == 0, i == 15);
    for (int i = 0; i < 16; i++) sendPix(i * 16, 0, i == 0, i == 15);

    // overlong frame: sum saturates, dT = 255 (R10)
    tag = "R10";
    setCfg(0, 1);
    for (int i = 0; i < 20; i++) sendPix(255, 0, i == 0, i == 19);
    setCfg(0, 1);
    for (int i = 0; i < 16; i++) sendPix(255, i, i == 0, i == 15);

    // stall: nothing accepted, outputs hold (R7)
    tag = "R7";
    stallSection = 1'b1;
    setCfg(20, 2);
    sendPix(1, 0, 1'b1, 1'b0);
    sendPix(200, 0, 1'b0, 1'b0);
    idle(0);
    @(posedge clk); #3 outReady = 1'b0;
    @(negedge clk);
    inValid = 1'b1; curPix = 8'd90; refPix = 8'd10; inSof = 1'b0; inEof = 1'b1;
    begin
      logic sv, sm, ss, se;
      sv = outValid; sm = outMask; ss = outSof; se = outEof;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(inReady == 1'b0, "R7", "inReady during stall", int'(inReady), 0);
        chk(outValid == sv && outMask == sm && outSof == ss && outEof == se,
            "R7", "outputs hold during stall", int'({outValid, outMask, outSof, outEof}),
            int'({sv, sm, ss, se}));
      end
    end
    @(posedge clk); #3 outReady = 1'b1;
    @(posedge clk);
    modelPush(90, 10, 1'b0, 1'b1);
    idle(4);
    stallSection = 1'b0;

    // sweep over many frames with varied settings (R1 R2 R3 R4)
    tag = "R3";
    for (int f = 0; f < 160; f++) begin
      setCfg((f * 13) % 200, f % 16);
      for (int i = 0; i < 16; i++)
        sendPix((i * 37 + f * 11) & 255, (i * 53 + f * 7 + 3 * i * f) & ((f % 4 == 0) ? 15 : 255),
                i == 0, i == 15);
    end

    idle(6);
    chk(qMask.size() == 0, "R6", "beats left undelivered", qMask.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule